// File: doc/BRIEF.md
# Storage PHY Control Register Bank

This block is a small memory-mapped register bank that sits between a host bus and the analog front end of a storage-interface PHY. It keeps six 16-bit control words whose fields drive the PHY's configuration pins directly: tap delays, clock-path selects, lane pull-ups, open-drain and receiver enables, DLL and power control. It also presents four status signals coming back from the PHY as one read-only word.

Every 32-bit write carries its own bit-mask in the upper half. A lower-half bit changes only when its mask partner is set, so software can update one field, such as the DLL enable, without reading the register first. Reads are answered one cycle after the request. After reset every control bit is zero, which leaves the PHY powered down with its DLL off.

Top module: `phy_ctl_regs`

## Requirements
- R1: After reset every control output is 0 (so `pwr_up` and `dll_en` are 0) and `bus_rvalid` is 0.
- R2: On a write to a control offset, stored bit i (0..15) takes `bus_wdata[i]` only when `bus_wdata[16+i]` is 1; every other bit keeps its value, and a write with an all-zero mask changes nothing.
- R3: Offset 0x00 is the tap word: bit 0 `in_tap_en`, bits 5:1 `in_tap_sel`, bit 6 `in_tap_win`, bits 10:7 `out_tap_sel`, bit 11 `out_tap_en`, bits 13:12 `freq_sel` (code 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz, 0 = 200 MHz).
- R4: Offsets 0x04 (receiver enable), 0x08 (pull-up) and 0x0C (open-drain enable) each hold bits 7:0 for the eight data lanes, bit 8 for the command line and bit 9 for the strobe line.
- R5: Offset 0x10 is the clock-path word: bits 3:0 `strb_sel`, bit 4 `rx_dly_clk`, bit 5 `tx_dly_clk`, bits 8:6 `clkbuf_sel`.
- R6: Offset 0x18 is the power word: bit 0 `pwr_up` (1 = powered, 0 = powered down), bit 1 `dll_en`, bit 2 `ret_on`, bit 3 `ret_off`, bits 6:4 `drv_type`, bit 7 `retrim`, bit 8 `trim_en`, bits 12:9 `dll_icp`.
- R7: A read request sets `bus_rvalid` for exactly the next cycle; for a control offset `bus_rdata` holds the stored 16 bits with bits 31:16 zero.
- R8: A read of offset 0x20 returns `{25'b0, cal_done, dll_ready, rtrim[3:0], ext_res}` (cal_done at bit 6, dll_ready bit 5, rtrim bits 4:1, ext_res bit 0) as seen on the inputs in the request cycle.
- R9: Writes to 0x20 or to any unmapped offset (such as 0x14 or 0x1C) change no control bit, and reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| cal_done | input | 1 | PHY calibration finished |
| dll_ready | input | 1 | PHY DLL locked |
| rtrim | input | 4 | PHY resistor trim value |
| ext_res | input | 1 | External resistor present |
| freq_sel | output | 2 | DLL frequency range code |
| out_tap_en | output | 1 | Output tap delay enable |
| out_tap_sel | output | 4 | Output tap delay select |
| in_tap_win | output | 1 | Input tap change window |
| in_tap_sel | output | 5 | Input tap delay select |
| in_tap_en | output | 1 | Input tap delay enable |
| rxen_dat | output | 8 | Data lane receiver enables |
| rxen_cmd | output | 1 | Command receiver enable |
| rxen_strb | output | 1 | Strobe receiver enable |
| pu_dat | output | 8 | Data lane pull-ups |
| pu_cmd | output | 1 | Command pull-up |
| pu_strb | output | 1 | Strobe pull-up |
| od_dat | output | 8 | Data lane open-drain enables |
| od_cmd | output | 1 | Command open-drain enable |
| od_strb | output | 1 | Strobe open-drain enable |
| strb_sel | output | 4 | Strobe delay select |
| rx_dly_clk | output | 1 | Use delayed receive clock |
| tx_dly_clk | output | 1 | Use delayed transmit clock |
| clkbuf_sel | output | 3 | Clock buffer select |
| pwr_up | output | 1 | PHY powered (active-low power-down) |
| dll_en | output | 1 | DLL enable |
| ret_on | output | 1 | Retention control |
| ret_off | output | 1 | Retention control, complement |
| drv_type | output | 3 | Driver strength type |
| retrim | output | 1 | Request resistor retrim |
| trim_en | output | 1 | Resistor trim enable |
| dll_icp | output | 4 | DLL charge-pump trim |

## Verification
The PHY may change its status inputs in the very cycle a status read is sampled, so the bench drives a read of 0x20 with one status pattern and replaces the pattern right after the capturing edge; the returned word must hold the request-cycle pattern, not the new one. Masked writes are judged against a bench-side copy of each control word, merging data under the mask, and read back both through the pins and through the bus so that a write hitting the wrong word or leaking into an unmasked bit shows up.

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic          cal_done,
  input  logic          dll_ready,
  input  logic [3:0]    rtrim,
  input  logic          ext_res,
  output logic [1:0]    freq_sel,
  output logic          out_tap_en,
  output logic [3:0]    out_tap_sel,
  output logic          in_tap_win,
  output logic [4:0]    in_tap_sel,
  output logic          in_tap_en,
  output logic [7:0]    rxen_dat,
  output logic          rxen_cmd,
  output logic          rxen_strb,
  output logic [7:0]    pu_dat,
  output logic          pu_cmd,
  output logic          pu_strb,
  output logic [7:0]    od_dat,
  output logic          od_cmd,
  output logic          od_strb,
  output logic [3:0]    strb_sel,
  output logic          rx_dly_clk,
  output logic          tx_dly_clk,
  output logic [2:0]    clkbuf_sel,
  output logic          pwr_up,
  output logic          dll_en,
  output logic          ret_on,
  output logic          ret_off,
  output logic [2:0]    drv_type,
  output logic          retrim,
  output logic          trim_en,
  output logic [3:0]    dll_icp
);
  localparam int DW = 16;
  localparam int NREG = 6;
  localparam int R_TAP = 0, R_RXEN = 1, R_PULL = 2, R_OD = 3, R_CLK = 4, R_PWR = 5;
  localparam logic [AW-1:0] STAT_OFF = AW'(8'h20);
  localparam logic [AW-1:0] PWR_OFF  = AW'(8'h18);

  logic [DW-1:0] ctl [NREG];
  logic [NREG-1:0] hit;
  logic [31:0] rd_word;
  logic [DW-1:0] wmask, wval;

  assign wmask = bus_wdata[31:16];
  assign wval  = bus_wdata[15:0];

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    if (g == R_PWR) begin : g_pwr
      assign hit[g] = bus_addr == PWR_OFF;
    end else begin : g_lin
      assign hit[g] = bus_addr == AW'(4 * g);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        ctl[i] <= '0;
      else if (bus_valid && bus_write && hit[i])
        ctl[i] <= (ctl[i] & ~wmask) | (wval & wmask);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_word = {16'h0, ctl[i]};
    if (bus_addr == STAT_OFF)
      rd_word = {25'h0, cal_done, dll_ready, rtrim, ext_res};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write)
        bus_rdata <= rd_word;
    end
  end

  assign in_tap_en   = ctl[R_TAP][0];
  assign in_tap_sel  = ctl[R_TAP][5:1];
  assign in_tap_win  = ctl[R_TAP][6];
  assign out_tap_sel = ctl[R_TAP][10:7];
  assign out_tap_en  = ctl[R_TAP][11];
  assign freq_sel    = ctl[R_TAP][13:12];

  assign rxen_dat  = ctl[R_RXEN][7:0];
  assign rxen_cmd  = ctl[R_RXEN][8];
  assign rxen_strb = ctl[R_RXEN][9];
  assign pu_dat    = ctl[R_PULL][7:0];
  assign pu_cmd    = ctl[R_PULL][8];
  assign pu_strb   = ctl[R_PULL][9];
  assign od_dat    = ctl[R_OD][7:0];
  assign od_cmd    = ctl[R_OD][8];
  assign od_strb   = ctl[R_OD][9];

  assign strb_sel   = ctl[R_CLK][3:0];
  assign rx_dly_clk = ctl[R_CLK][4];
  assign tx_dly_clk = ctl[R_CLK][5];
  assign clkbuf_sel = ctl[R_CLK][8:6];

  assign pwr_up   = ctl[R_PWR][0];
  assign dll_en   = ctl[R_PWR][1];
  assign ret_on   = ctl[R_PWR][2];
  assign ret_off  = ctl[R_PWR][3];
  assign drv_type = ctl[R_PWR][6:4];
  assign retrim   = ctl[R_PWR][7];
  assign trim_en  = ctl[R_PWR][8];
  assign dll_icp  = ctl[R_PWR][12:9];
endmodule

// File: rtl/phy_ctl_regs_chk.sv
module phy_ctl_regs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          bus_rvalid,
  input logic          cal_done,
  input logic          dll_ready,
  input logic [3:0]    rtrim,
  input logic          ext_res,
  input logic          pwr_up,
  input logic          dll_en,
  input logic [1:0]    freq_sel,
  input logic [7:0]    rxen_dat
);
  logic wr_pwr, wr_stat, rd_req, rd_stat;
  assign wr_pwr  = bus_valid && bus_write && bus_addr == AW'(8'h18);
  assign wr_stat = bus_valid && bus_write && bus_addr == AW'(8'h20);
  assign rd_req  = bus_valid && !bus_write;
  assign rd_stat = rd_req && bus_addr == AW'(8'h20);

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pwr && !bus_wdata[16] |=> $stable(pwr_up));

  assert_mask_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pwr && bus_wdata[17] |=> dll_en == $past(bus_wdata[1]));

  assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> $stable(pwr_up) && $stable(dll_en) && $stable(freq_sel) && $stable(rxen_dat));

  assert_rvalid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_rvalid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[31:16] == 16'h0);

  assert_status_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> bus_rdata == {25'h0, $past(cal_done), $past(dll_ready), $past(rtrim), $past(ext_res)});
endmodule

bind phy_ctl_regs phy_ctl_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .cal_done(cal_done), .dll_ready(dll_ready),
  .rtrim(rtrim), .ext_res(ext_res), .pwr_up(pwr_up), .dll_en(dll_en),
  .freq_sel(freq_sel), .rxen_dat(rxen_dat)
);

// File: tb/phy_ctl_regs_tb.sv
`timescale 1ns/1ps
module phy_ctl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic cal_done = 1'b0, dll_ready = 1'b0, ext_res = 1'b0;
  logic [3:0] rtrim = '0;
  logic [1:0] freq_sel;
  logic out_tap_en, in_tap_win, in_tap_en;
  logic [3:0] out_tap_sel, strb_sel, dll_icp;
  logic [4:0] in_tap_sel;
  logic [7:0] rxen_dat, pu_dat, od_dat;
  logic rxen_cmd, rxen_strb, pu_cmd, pu_strb, od_cmd, od_strb;
  logic rx_dly_clk, tx_dly_clk;
  logic [2:0] clkbuf_sel, drv_type;
  logic pwr_up, dll_en, ret_on, ret_off, retrim, trim_en;

  int checks = 0, errors = 0;
  logic [15:0] shadow [6];

  always #10 clk = ~clk;

  phy_ctl_regs u_dut (.*);

  function automatic logic [15:0] pins(int r);
    case (r)
      0: pins = {2'b0, freq_sel, out_tap_en, out_tap_sel, in_tap_win, in_tap_sel, in_tap_en};
      1: pins = {6'b0, rxen_strb, rxen_cmd, rxen_dat};
      2: pins = {6'b0, pu_strb, pu_cmd, pu_dat};
      3: pins = {6'b0, od_strb, od_cmd, od_dat};
      4: pins = {7'b0, clkbuf_sel, tx_dly_clk, rx_dly_clk, strb_sel};
      default: pins = {3'b0, dll_icp, trim_en, retrim, drv_type, ret_off, ret_on, dll_en, pwr_up};
    endcase
  endfunction

  function automatic logic [15:0] used(int r);
    case (r)
      0: used = 16'h3FFF;
      1, 2, 3: used = 16'h03FF;
      4: used = 16'h01FF;
      default: used = 16'h1FFF;
    endcase
  endfunction

  function automatic logic [7:0] off(int r);
    off = (r == 5) ? 8'h18 : 8'(4 * r);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    for (int r = 0; r < 6; r++)
      if (a == off(r)) shadow[r] = (shadow[r] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    q = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic check_all_pins(string req);
    for (int r = 0; r < 6; r++)
      check(req, {16'h0, pins(r)}, {16'h0, shadow[r] & used(r)});
  endtask

  task automatic t_reset_r1;
    check("R1 reset pins", {pwr_up, dll_en, bus_rvalid}, 0);
    check_all_pins("R1 reset all controls zero");
  endtask

  task automatic t_mask_r2_r6;
    wr(8'h18, 32'h0001_FFFF);
    check("R2/R6 only pwr_up set", {pwr_up, dll_en}, 2'b10);
    wr(8'h18, 32'h0002_0002);
    check("R2/R6 dll_en set, pwr_up kept", {pwr_up, dll_en}, 2'b11);
    wr(8'h18, 32'h0000_0000);
    check("R2 zero mask no change", {pwr_up, dll_en}, 2'b11);
    wr(8'h18, 32'h1FFC_1A74);
    check("R6 power word fields", {16'h0, pins(5)}, {16'h0, shadow[5]});
    check("R6 drive type", drv_type, 3'd7);
    check("R6 dll trim", dll_icp, 4'hD);
  endtask

  task automatic t_tap_r3;
    wr(8'h00, 32'hFFFF_2A55);
    check("R3 freq 100MHz code", freq_sel, 2'd2);
    check("R3 out tap sel", out_tap_sel, 4'd4);
    check("R3 in tap sel", in_tap_sel, 5'd10);
    check("R3 enables", {out_tap_en, in_tap_win, in_tap_en}, 3'b111);
    wr(8'h00, 32'h3000_1000);
    check("R3 freq 50MHz code via masked write", freq_sel, 2'd1);
    check_all_pins("R3 other tap fields kept");
  endtask

  task automatic t_lines_r4_r5;
    wr(8'h04, 32'h03FF_0255);
    wr(8'h08, 32'h03FF_01AA);
    wr(8'h0C, 32'h0300_0300);
    wr(8'h10, 32'h01FF_0163);
    check("R4 rx enables", {rxen_strb, rxen_cmd, rxen_dat}, 10'h255);
    check("R4 pull cmd line", {pu_strb, pu_cmd}, 2'b01);
    check("R4 open-drain cmd+strb only", {od_strb, od_cmd, od_dat}, 10'h300);
    check("R5 clock path", {clkbuf_sel, tx_dly_clk, rx_dly_clk, strb_sel}, 9'h163);
    check_all_pins("R4/R5 all words");
  endtask

  task automatic t_read_r7;
    logic [31:0] q;
    for (int r = 0; r < 6; r++) begin
      rd(off(r), q);
      check("R7 readback", q, {16'h0, shadow[r]});
    end
    wr(8'h04, 32'hFC00_FC00);
    rd(8'h04, q);
    check("R7 unused bits stored, upper zero", q, {16'h0, shadow[1]});
    @(negedge clk);
    check("R7 rvalid one cycle only", bus_rvalid, 1'b0);
  endtask

  task automatic t_status_r8;
    logic [31:0] q;
    cal_done = 1'b1; dll_ready = 1'b0; rtrim = 4'hA; ext_res = 1'b1;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h20;
    @(posedge clk);
    #1 cal_done = 1'b0; dll_ready = 1'b1; rtrim = 4'h5; ext_res = 1'b0;
    @(negedge clk);
    bus_valid = 1'b0;
    q = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    check("R8 status sampled in request cycle", q, 32'h0000_0055);
    rd(8'h20, q);
    check("R8 status new value", q, 32'h0000_002A);
  endtask

  task automatic t_ignored_r9;
    logic [31:0] q;
    wr(8'h20, 32'hFFFF_0000);
    check_all_pins("R9 status write ignored");
    wr(8'h14, 32'hFFFF_0000);
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h24, 32'hFFFF_0000);
    check_all_pins("R9 unmapped writes ignored");
    rd(8'h14, q);
    check("R9 unmapped read zero", q, 32'h0);
    rd(8'h18, q);
    check("R9 power word intact", q, {16'h0, shadow[5]});
  endtask

  initial begin
    for (int r = 0; r < 6; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1;
    t_mask_r2_r6;
    t_tap_r3;
    t_lines_r4_r5;
    t_read_r7;
    t_status_r8;
    t_ignored_r9;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule